// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two entries of a page table that sits in physical memory. A caller hands it a virtual address together with the kind of access (read or write, user or supervisor). The walker then reads the first-level entry at an address formed from the table base and the top index field. It checks that entry, and on success reads the second-level entry from the frame the first entry names. It returns either the translated address or a fault kind together with the level that stopped the walk.

The virtual address has three fields: a 10-bit first-level index in the top bits, a 10-bit second-level index in the middle, and a 12-bit page offset at the bottom. Entries are one 32-bit word each. An entry holds its frame number in bits [31:12], a user-accessible flag in bit 3, a write-allowed flag in bit 2, a read-allowed flag in bit 1 and a valid flag in bit 0. Bits [11:4] are ignored. Memory is a single-word read port. The walker raises a request and holds it with a steady address until the memory returns the data, which may take any number of cycles.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk targets the latched table base plus 4 times VA[31:22].
- R2: After a first-level entry passes its checks, the second read targets {entry[31:12], 12'h000} plus 4 times VA[21:12].
- R3: A walk whose two entries both pass returns fault code 0, level 0 and the physical address {second entry[31:12], VA[11:0]}.
- R4: A first-level entry with bit 0 clear ends the walk with no second read, fault code 1 (page fault), level 1 and address 0.
- R5: A second-level entry with bit 0 clear ends the walk with fault code 1, level 2 and address 0.
- R6: A valid entry fails its rights check when a read finds bit 1 clear, a write finds bit 2 clear, or a user access finds bit 3 clear. Supervisor accesses ignore bit 3. A failure gives fault code 2 (protection fault) at that entry's level and address 0. The valid check takes priority over the rights check.
- R7: `req_ready_o` is high only when idle. A request offered while a walk is running is ignored and does not change the result.
- R8: The result and `resp_valid_o` stay unchanged until `resp_ack_i`. One cycle after an acknowledged result, the walker is idle again.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until a cycle in which `mem_rvalid_i` is high, whatever the latency.
- R10: After reset the walker is idle, with `req_ready_o` high and both `mem_req_o` and `resp_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base_i | input | 32 | Physical address of the first-level table, latched when a request is taken |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker is idle and takes the request this cycle |
| req_va_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| req_user_i | input | 1 | 1 for a user-mode access |
| mem_req_o | output | 1 | Entry read outstanding |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data returned this cycle |
| mem_rdata_i | input | 32 | Entry word returned by memory |
| resp_valid_o | output | 1 | Result available |
| resp_ack_i | input | 1 | Caller takes the result |
| resp_pa_o | output | 32 | Physical address, 0 on a fault |
| resp_fault_o | output | 2 | 0 none, 1 page fault, 2 protection fault |
| resp_level_o | output | 2 | 0 on success, else the level (1 or 2) that faulted |

## Verification
The bench builds the walker with its default fields, 10/10/12 bits and 32-bit entries. These are small enough to sweep all 16 flag patterns of the first entry against all 16 of the second entry, for every mix of read, write, user and supervisor access. That covers every fault kind at both levels and the priority of the valid flag over the rights flags. Virtual addresses, table bases and frame numbers come from an arithmetic sequence that includes the all-zero and all-one address. Memory latency cycles through 0 to 4 wait cycles, so the request-hold rule and an ignored mid-walk request are both exercised at every latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_RD_L1 = 2'd1,
    WS_RD_L2 = 2'd2,
    WS_DONE  = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_PAGE = 2'd1,
    FK_PROT = 2'd2
  } fault_kind_e;

  // Flag positions inside an entry word; the frame number sits above the offset width.
  localparam int FLAG_VALID = 0;
  localparam int FLAG_READ  = 1;
  localparam int FLAG_WRITE = 2;
  localparam int FLAG_USER  = 3;
  localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX1_W = 10,
  parameter int IDX2_W = 10,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32
) (
  input  logic [PA_W-1:0]                 base_i,
  input  logic [IDX1_W+IDX2_W+OFF_W-1:0]  va_i,
  input  logic [PA_W-OFF_W-1:0]           frame_l1_i,
  input  logic [PA_W-OFF_W-1:0]           frame_l2_i,
  output logic [PA_W-1:0]                 l1_addr_o,
  output logic [PA_W-1:0]                 l2_addr_o,
  output logic [PA_W-1:0]                 pa_o
);
  localparam int VA_W    = IDX1_W + IDX2_W + OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int ENT_LG  = $clog2(PTE_W / 8);

  function automatic logic [PA_W-1:0] l1_entry(input logic [PA_W-1:0] tbl,
                                               input logic [IDX1_W-1:0] ix);
    return tbl + (PA_W'(ix) << ENT_LG);
  endfunction

  function automatic logic [PA_W-1:0] l2_entry(input logic [FRAME_W-1:0] frm,
                                               input logic [IDX2_W-1:0] ix);
    return {frm, {OFF_W{1'b0}}} + (PA_W'(ix) << ENT_LG);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] frm,
                                              input logic [OFF_W-1:0] off);
    return {frm, off};
  endfunction

  logic [IDX1_W-1:0] idx1;
  logic [IDX2_W-1:0] idx2;
  logic [OFF_W-1:0]  offs;

  assign idx1 = va_i[VA_W-1 -: IDX1_W];
  assign idx2 = va_i[OFF_W +: IDX2_W];
  assign offs = va_i[OFF_W-1:0];

  assign l1_addr_o = l1_entry(base_i, idx1);
  assign l2_addr_o = l2_entry(frame_l1_i, idx2);
  assign pa_o      = join_pa(frame_l2_i, offs);

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0]      pte_i,
  input  logic                  is_write_i,
  input  logic                  is_user_i,
  output fault_kind_e           kind_o,
  output logic [PA_W-OFF_W-1:0] frame_o
);
  localparam int FRAME_W = PA_W - OFF_W;

  function automatic logic rights_ok(input logic [PTE_W-1:0] e,
                                     input logic wr, input logic usr);
    logic need_rw;
    logic need_u;
    need_rw = wr ? e[FLAG_WRITE] : e[FLAG_READ];
    need_u  = usr ? e[FLAG_USER] : 1'b1;
    return need_rw && need_u;
  endfunction

  logic unused_pte_rsvd;
  assign unused_pte_rsvd = ^pte_i[OFF_W-1:FLAG_COUNT];

  assign frame_o = pte_i[PTE_W-1 -: FRAME_W];

  always_comb begin
    if (!pte_i[FLAG_VALID])                        kind_o = FK_PAGE;
    else if (!rights_ok(pte_i, is_write_i, is_user_i)) kind_o = FK_PROT;
    else                                           kind_o = FK_NONE;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IDX1_W = 10,
  parameter int IDX2_W = 10,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [PA_W-1:0]                  pt_base_i,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic [IDX1_W+IDX2_W+OFF_W-1:0]   req_va_i,
  input  logic                             req_write_i,
  input  logic                             req_user_i,
  output logic                             mem_req_o,
  output logic [PA_W-1:0]                  mem_addr_o,
  input  logic                             mem_rvalid_i,
  input  logic [PTE_W-1:0]                 mem_rdata_i,
  output logic                             resp_valid_o,
  input  logic                             resp_ack_i,
  output logic [PA_W-1:0]                  resp_pa_o,
  output logic [1:0]                       resp_fault_o,
  output logic [1:0]                       resp_level_o
);
  localparam int VA_W    = IDX1_W + IDX2_W + OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;

  walk_state_e        state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic               usr_q;
  logic [PA_W-1:0]    base_q;
  logic [FRAME_W-1:0] frame1_q;
  logic [PA_W-1:0]    pa_q;
  fault_kind_e        fault_q;
  logic [1:0]         level_q;

  // Named events for the assertions and the FSM.
  logic               ev_accept;
  logic               ev_data_take;
  logic               ev_resp_ack;
  fault_kind_e        chk_kind;
  logic [FRAME_W-1:0] chk_frame;
  logic [PA_W-1:0]    l1_addr;
  logic [PA_W-1:0]    l2_addr;
  logic [PA_W-1:0]    pa_w;

  assign req_ready_o  = (state_q == WS_IDLE);
  assign mem_req_o    = (state_q == WS_RD_L1) || (state_q == WS_RD_L2);
  assign resp_valid_o = (state_q == WS_DONE);
  assign ev_accept    = req_valid_i && req_ready_o;
  assign ev_data_take = mem_req_o && mem_rvalid_i;
  assign ev_resp_ack  = resp_valid_o && resp_ack_i;

  ptw_addr_gen #(
    .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) addr_gen_i (
    .base_i     (base_q),
    .va_i       (va_q),
    .frame_l1_i (frame1_q),
    .frame_l2_i (chk_frame),
    .l1_addr_o  (l1_addr),
    .l2_addr_o  (l2_addr),
    .pa_o       (pa_w)
  );

  ptw_pte_check #(
    .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) pte_check_i (
    .pte_i      (mem_rdata_i),
    .is_write_i (wr_q),
    .is_user_i  (usr_q),
    .kind_o     (chk_kind),
    .frame_o    (chk_frame)
  );

  assign mem_addr_o   = (state_q == WS_RD_L2) ? l2_addr : l1_addr;
  assign resp_pa_o    = pa_q;
  assign resp_fault_o = fault_q;
  assign resp_level_o = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      usr_q    <= 1'b0;
      base_q   <= '0;
      frame1_q <= '0;
      pa_q     <= '0;
      fault_q  <= FK_NONE;
      level_q  <= 2'd0;
    end else begin
      case (state_q)
        WS_IDLE: begin
          if (ev_accept) begin
            va_q    <= req_va_i;
            wr_q    <= req_write_i;
            usr_q   <= req_user_i;
            base_q  <= pt_base_i;
            state_q <= WS_RD_L1;
          end
        end
        WS_RD_L1: begin
          if (ev_data_take) begin
            if (chk_kind != FK_NONE) begin
              fault_q <= chk_kind;
              level_q <= 2'd1;
              pa_q    <= '0;
              state_q <= WS_DONE;
            end else begin
              frame1_q <= chk_frame;
              state_q  <= WS_RD_L2;
            end
          end
        end
        WS_RD_L2: begin
          if (ev_data_take) begin
            fault_q <= chk_kind;
            level_q <= (chk_kind == FK_NONE) ? 2'd0 : 2'd2;
            pa_q    <= (chk_kind == FK_NONE) ? pa_w : '0;
            state_q <= WS_DONE;
          end
        end
        default: begin
          if (ev_resp_ack) state_q <= WS_IDLE;
        end
      endcase
    end
  end

  // R10: reset leaves the walker idle
  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> (req_ready_o && !mem_req_o && !resp_valid_o));

  // R7: never ready while a read is outstanding or a result is pending
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o || resp_valid_o) |-> !req_ready_o);

  // R9: read request and address held until data returns
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8: result stable until acknowledged
  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && !resp_ack_i) |=>
      (resp_valid_o && $stable(resp_pa_o) && $stable(resp_fault_o) && $stable(resp_level_o)));

  // R8: acknowledged result returns the walker to idle
  assert_ack_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_ack |=> req_ready_o);

  // R4: a first-level page fault never issues a second read
  assert_l1_fault_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_RD_L1 && ev_data_take && !mem_rdata_i[FLAG_VALID]) |=>
      (!mem_req_o && resp_valid_o && resp_level_o == 2'd1));

  // R3: success carries level 0 and a faulting result carries level 1 or 2
  assert_level_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> ((resp_fault_o == 2'd0) == (resp_level_o == 2'd0)));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_va;
  logic        req_write;
  logic        req_user;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        resp_valid;
  logic        resp_ack;
  logic [31:0] resp_pa;
  logic [1:0]  resp_fault;
  logic [1:0]  resp_level;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .pt_base_i(pt_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_write_i(req_write), .req_user_i(req_user),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .resp_valid_o(resp_valid), .resp_ack_i(resp_ack),
    .resp_pa_o(resp_pa), .resp_fault_o(resp_fault), .resp_level_o(resp_level)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Rights test as stated in R6.
  function automatic bit rights_bad(input logic [3:0] f, input bit wr, input bit usr);
    bit bad;
    bad = wr ? !f[2] : !f[1];
    if (usr && !f[3]) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic [1:0] kind_of(input logic [3:0] f, input bit wr, input bit usr);
    if (!f[0]) return 2'd1;
    if (rights_bad(f, wr, usr)) return 2'd2;
    return 2'd0;
  endfunction

  task automatic serve(input string rq, input logic [31:0] exp_addr,
                       input logic [31:0] data, input int lat);
    chk({rq, " read raised"}, {31'd0, mem_req}, 32'd1);
    chk({rq, " read address"}, mem_addr, exp_addr);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R9 hold request", {31'd0, mem_req}, 32'd1);
      chk("R9 hold address", mem_addr, exp_addr);
      chk("R7 ready low while busy", {31'd0, req_ready}, 32'd0);
    end
    mem_rvalid = 1'b1;
    mem_rdata  = data;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 32'hDEAD_BEEF;
  endtask

  task automatic walk(input int n, input logic [31:0] va, input logic [31:0] base,
                      input logic [3:0] f1, input logic [3:0] f2,
                      input bit wr, input bit usr);
    logic [31:0] pte1, pte2, a1, a2, exp_pa;
    logic [1:0]  k1, k2, exp_f, exp_l;
    int lat;
    lat  = n % 5;
    pte1 = {(va[31:12] ^ 20'h5A5A5) + 20'(n), 8'hC3, f1};
    pte2 = {20'(n * 13) ^ 20'hF0F0F, 8'h3C, f2};
    a1 = base + {20'd0, va[31:22], 2'b00};
    a2 = {pte1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    k1 = kind_of(f1, wr, usr);
    k2 = kind_of(f2, wr, usr);
    if (k1 != 2'd0) begin exp_f = k1; exp_l = 2'd1; exp_pa = 32'd0; end
    else if (k2 != 2'd0) begin exp_f = k2; exp_l = 2'd2; exp_pa = 32'd0; end
    else begin exp_f = 2'd0; exp_l = 2'd0; exp_pa = {pte2[31:12], va[11:0]}; end

    chk("R7 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_va = va; pt_base = base; req_write = wr; req_user = usr;
    @(negedge clk);
    // R7: a competing request during the walk must be ignored.
    req_va = ~va; pt_base = base ^ 32'h0010_0000; req_write = ~wr; req_user = ~usr;
    serve("R1", a1, pte1, lat);
    if (k1 != 2'd0) begin
      chk("R4 no second read", {31'd0, mem_req}, 32'd0);
    end else begin
      serve("R2", a2, pte2, (lat + 2) % 5);
    end
    req_valid = 1'b0;
    chk("R8 result valid", {31'd0, resp_valid}, 32'd1);
    chk(k1 == 2'd1 ? "R4 fault" : (exp_f == 2'd2 ? "R6 fault" :
        (exp_f == 2'd1 ? "R5 fault" : "R3 fault")), {30'd0, resp_fault}, {30'd0, exp_f});
    chk(exp_f == 2'd2 ? "R6 level" : "R3 level", {30'd0, resp_level}, {30'd0, exp_l});
    chk(exp_f == 2'd0 ? "R3 physical address" : "R5 address zero", resp_pa, exp_pa);
    if (n % 2 == 1) begin
      @(negedge clk);
      chk("R8 held valid", {31'd0, resp_valid}, 32'd1);
      chk("R8 held address", resp_pa, exp_pa);
      chk("R8 held fault", {30'd0, resp_fault}, {30'd0, exp_f});
    end
    resp_ack = 1'b1;
    @(negedge clk);
    resp_ack = 1'b0;
    chk("R8 idle after ack", {30'd0, req_ready, resp_valid}, 32'd2);
  endtask

  initial begin
    req_valid = 0; req_va = 0; pt_base = 0; req_write = 0; req_user = 0;
    mem_rvalid = 0; mem_rdata = 0; resp_ack = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R10 reset no read", {31'd0, mem_req}, 32'd0);
    chk("R10 reset no result", {31'd0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] va, base;
      if (i == 0) va = 32'h0000_0000;
      else if (i == 1) va = 32'hFFFF_FFFF;
      else va = 32'(i) * 32'h9E37_79B9;
      base = 32'h0004_0000 + (32'(i) << 12) + 32'((i % 3) * 4);
      walk(i, va, base, 4'(i), 4'(i >> 4), i[8], i[9]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule